// File: doc/BRIEF.md
# Busy-Line Bus Access Agent

This block sits between one would-be bus initiator and a shared bus that has no central arbiter. Every agent on the bus drives one bit of a shared claim vector, and the wired-OR of that vector is the bus busy line. When the local initiator raises its transfer request, the agent looks at the busy line. If another agent holds the bus, it waits. Once the line is free, it raises its own claim bit and keeps it up for a one-cycle claim window.

If no other claim bit is set during that window, the agent takes the bus and asserts its ownership output until the local side pulses transaction-done. If any other bit is set, two agents have claimed together. The agent then drops its claim without ever signalling ownership. It waits a pseudo-random number of cycles, drawn from an 8-bit LFSR seeded with a per-agent constant, and then tries again, starting from the busy check.

The claim vector is assembled outside the block. The agent's own claim output must be fed back into bit `AGENT_ID` of `claim_vec`. Data transfer itself is not part of the block.

Top module: `busy_line_agent`

## Requirements
- R1: A synchronous active-high reset clears `claim_out`, `owner` and the backoff delay, and the agent comes out of reset idle.
- R2: When idle with `xfer_req` high and every bit of `claim_vec` low at a clock edge, the agent raises `claim_out` after that edge (start of the claim window) while `owner` stays low.
- R3: If, at the edge that ends the claim window, no bit of `claim_vec` other than bit `AGENT_ID` is set, `owner` rises after that edge and `claim_out` stays high.
- R4: While `xfer_req` is high and any bit of `claim_vec` is set, a non-claiming agent keeps `claim_out` low; it raises `claim_out` after the first edge at which all bits are seen low.
- R5: If any bit other than bit `AGENT_ID` is set at the edge ending the claim window, `claim_out` falls after that edge and `owner` never rises for that attempt.
- R6: After a collision the agent waits a backoff of 1 to 16 cycles and then rechecks the busy line, so with the bus free `claim_out` stays low for 2 to 17 sampled cycles before the next claim.
- R7: A one-cycle `xfer_done` pulse while `owner` is high drops both `owner` and `claim_out` after that edge, and the agent returns to idle.
- R8: If `xfer_req` falls while the agent is deferring, it returns to idle and does not claim when the bus later frees.
- R9: `xfer_done` has no effect while the agent does not own the bus: outputs stay low and a following request proceeds normally.
- R10: `owner` is never high while `claim_out` is low, so an agent never signals ownership without holding the busy line.
- R11: The backoff length comes from an 8-bit LFSR that starts at the per-agent seed, advances every cycle and never reaches zero, so repeated collisions yield varying delays.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Local initiator wants the bus (held until served) |
| xfer_done | input | 1 | One-cycle pulse: local transaction finished |
| claim_vec | input | N_AGENTS | Claim bits of all agents; OR of them is the busy line; bit AGENT_ID is this agent's own claim fed back |
| claim_out | output | 1 | This agent's claim bit, high in the claim window and while owning |
| owner | output | 1 | Bus is held by this agent; initiator may drive bus control |

## Verification
The bench builds the agent with four agents on the claim vector, `AGENT_ID` 0, seed 8'h5B and a 4-bit backoff field. With these values, the full 1-to-16-cycle backoff range can be reached by forcing a collision on every attempt. Rival claims are injected on other bits, both during the claim window and before a request, so that the defer, collision, retry and release paths are all taken. Measuring the low gap over several forced collisions shows both the delay bounds and that the LFSR produces different values.

// File: rtl/busy_line_agent_pkg.sv
package busy_line_agent_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_CLAIM,
        ST_OWN,
        ST_BACKOFF
    } agent_state_e;

    localparam int LFSR_W = 8;

    // Fibonacci step, polynomial x^8 + x^6 + x^5 + x^4 + 1 (maximal length)
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic fb;
        fb = s[7] ^ s[5] ^ s[4] ^ s[3];
        return {s[LFSR_W-2:0], fb};
    endfunction

    function automatic logic is_claiming(input agent_state_e st);
        return (st == ST_CLAIM) || (st == ST_OWN);
    endfunction

endpackage

// File: rtl/busy_line_agent_lfsr.sv
module busy_line_agent_lfsr
    import busy_line_agent_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 8'h5B
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] value
);

    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= lfsr_step(state_q);
    end

    assign value = state_q;

    // R11: a non-zero seed keeps the register out of the lock-up state
    a_r11_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/busy_line_agent_backoff.sv
module busy_line_agent_backoff #(
    parameter int BO_BITS = 4,
    localparam int CNT_W  = BO_BITS + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [BO_BITS-1:0] load_val,
    output logic               expired
);

    localparam logic [CNT_W-1:0] MAX_WAIT = CNT_W'(1 << BO_BITS);

    logic [CNT_W-1:0] cnt_q;
    logic             active;

    assign active  = (cnt_q != '0);
    assign expired = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (load)   cnt_q <= CNT_W'(load_val) + CNT_W'(1);
        else if (active) cnt_q <= cnt_q - CNT_W'(1);
    end

    // R6: the pending wait never exceeds the largest backoff
    a_r6_wait_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= MAX_WAIT);

    // R6: a running wait counts down by exactly one each cycle
    a_r6_counts_down: assert property (@(posedge clk) disable iff (rst)
        (active && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/busy_line_agent_fsm.sv
module busy_line_agent_fsm
    import busy_line_agent_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int AGENT_ID = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                xfer_req,
    input  logic                xfer_done,
    input  logic [N_AGENTS-1:0] claim_vec,
    input  logic                bo_expired,
    output logic                bo_load,
    output logic                claim_out,
    output logic                owner
);

    localparam logic [N_AGENTS-1:0] SELF_MASK = N_AGENTS'(1) << AGENT_ID;

    agent_state_e state_q, state_d;
    logic         bus_busy;
    logic         rivals;

    assign bus_busy = |claim_vec;
    assign rivals   = |(claim_vec & ~SELF_MASK);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (xfer_req) state_d = bus_busy ? ST_DEFER : ST_CLAIM;
            ST_DEFER:   if (!xfer_req)     state_d = ST_IDLE;
                        else if (!bus_busy) state_d = ST_CLAIM;
            ST_CLAIM:   state_d = rivals ? ST_BACKOFF : ST_OWN;
            ST_OWN:     if (xfer_done)  state_d = ST_IDLE;
            ST_BACKOFF: if (bo_expired) state_d = ST_DEFER;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign bo_load   = (state_q == ST_CLAIM) && rivals;
    assign claim_out = is_claiming(state_q);
    assign owner     = (state_q == ST_OWN);

    // R4: a non-claiming agent that sees the line busy does not claim next cycle
    a_r4_defer_on_busy: assert property (@(posedge clk) disable iff (rst)
        (!claim_out && bus_busy) |=> !claim_out);

    // R5: a collided claim window never leads to ownership
    a_r5_collision_backs_off: assert property (@(posedge clk) disable iff (rst)
        (claim_out && !owner && rivals) |=> (!claim_out && !owner));

    // R3: an uncontested claim window yields ownership
    a_r3_clean_window_wins: assert property (@(posedge clk) disable iff (rst)
        (claim_out && !owner && !rivals) |=> owner);

    // R7: done while owning releases the line on the next edge
    a_r7_done_releases: assert property (@(posedge clk) disable iff (rst)
        (owner && xfer_done) |=> (!claim_out && !owner));

    // R10: ownership is only ever reached through a claim window
    a_r10_owner_via_claim: assert property (@(posedge clk) disable iff (rst)
        $rose(owner) |-> $past(claim_out));

endmodule

// File: rtl/busy_line_agent.sv
module busy_line_agent
    import busy_line_agent_pkg::*;
#(
    parameter int                N_AGENTS = 4,
    parameter int                AGENT_ID = 0,
    parameter logic [LFSR_W-1:0] SEED     = 8'h5B,
    parameter int                BO_BITS  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                xfer_req,
    input  logic                xfer_done,
    input  logic [N_AGENTS-1:0] claim_vec,
    output logic                claim_out,
    output logic                owner
);

    logic [LFSR_W-1:0] rnd;
    logic              bo_load;
    logic              bo_expired;

    busy_line_agent_lfsr #(
        .SEED (SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .value (rnd)
    );

    busy_line_agent_backoff #(
        .BO_BITS (BO_BITS)
    ) u_backoff (
        .clk      (clk),
        .rst      (rst),
        .load     (bo_load),
        .load_val (rnd[BO_BITS-1:0]),
        .expired  (bo_expired)
    );

    busy_line_agent_fsm #(
        .N_AGENTS (N_AGENTS),
        .AGENT_ID (AGENT_ID)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .xfer_req   (xfer_req),
        .xfer_done  (xfer_done),
        .claim_vec  (claim_vec),
        .bo_expired (bo_expired),
        .bo_load    (bo_load),
        .claim_out  (claim_out),
        .owner      (owner)
    );

    // R10: ownership implies the busy line is held by this agent
    a_r10_owner_holds_line: assert property (@(posedge clk) disable iff (rst)
        owner |-> claim_out);

endmodule

// File: tb/busy_line_agent_tb.sv
module busy_line_agent_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;

    typedef struct {
        logic  claim;
        logic  own;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst;
    logic         xfer_req;
    logic         xfer_done;
    logic [N-1:0] rival;
    logic [N-1:0] claim_vec;
    logic         claim_out;
    logic         owner;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign claim_vec = {rival[N-1:1], claim_out};

    busy_line_agent #(
        .N_AGENTS (N),
        .AGENT_ID (0),
        .SEED     (8'h5B),
        .BO_BITS  (4)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .xfer_req  (xfer_req),
        .xfer_done (xfer_done),
        .claim_vec (claim_vec),
        .claim_out (claim_out),
        .owner     (owner)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: inputs are set at a negedge; the expectation is for after the next posedge
    task automatic expect_cycle(input logic c, input logic o, input string tag);
        exp_t e;
        e.claim = c; e.own = o; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(claim_out == e.claim, {e.tag, " claim"}, int'(claim_out), int'(e.claim));
                check(owner == e.own, {e.tag, " owner"}, int'(owner), int'(e.own));
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // force collisions, measure the low gap before each retry; returns gap
    task automatic collide_and_measure(output int gap);
        gap = 0;
        // we are at a negedge with claim_out high and owner low (claim window)
        rival = 4'b0100;
        @(posedge clk); #1;
        check(!claim_out && !owner, "R5 collision drops claim", int'(claim_out), 0);
        @(negedge clk);
        rival = '0;
        gap = 1;
        while (1) begin
            @(posedge clk); #1;
            if (owner) check(1'b0, "R5 owner during backoff", 1, 0);
            if (claim_out) break;
            gap++;
            if (gap > 40) break;
        end
        @(negedge clk);
    endtask

    initial begin
        int gaps[6];
        int distinct;
        rst = 1'b1; xfer_req = 1'b0; xfer_done = 1'b0; rival = '0;
        repeat (3) @(negedge clk);
        check(!claim_out && !owner, "R1 reset state", int'(claim_out | owner), 0);
        rst = 1'b0;

        // R2/R3/R7: clean acquire and release
        xfer_req = 1'b1;
        expect_cycle(1, 0, "R2 claim window");
        expect_cycle(1, 1, "R3 win");
        expect_cycle(1, 1, "R3 hold");
        xfer_done = 1'b1;
        expect_cycle(0, 0, "R7 release");
        xfer_done = 1'b0; xfer_req = 1'b0;
        expect_cycle(0, 0, "R7 idle");

        // R4: defer while busy, claim once free
        rival = 4'b0010; xfer_req = 1'b1;
        expect_cycle(0, 0, "R4 defer 1");
        expect_cycle(0, 0, "R4 defer 2");
        expect_cycle(0, 0, "R4 defer 3");
        rival = '0;
        expect_cycle(1, 0, "R4 claim after free");
        expect_cycle(1, 1, "R4 owns");
        xfer_done = 1'b1;
        expect_cycle(0, 0, "R7 release 2");
        xfer_done = 1'b0; xfer_req = 1'b0;
        expect_cycle(0, 0, "R7 idle 2");

        // R8: request withdrawn while deferring
        rival = 4'b1000; xfer_req = 1'b1;
        expect_cycle(0, 0, "R8 defer");
        xfer_req = 1'b0;
        expect_cycle(0, 0, "R8 withdraw");
        rival = '0;
        expect_cycle(0, 0, "R8 no claim 1");
        expect_cycle(0, 0, "R8 no claim 2");

        // R9: done while not owning is ignored
        xfer_done = 1'b1;
        expect_cycle(0, 0, "R9 stray done");
        xfer_done = 1'b0; xfer_req = 1'b1;
        expect_cycle(1, 0, "R9 claim after stray done");
        expect_cycle(1, 1, "R9 owns");
        xfer_done = 1'b1;
        expect_cycle(0, 0, "R9 release");
        xfer_done = 1'b0; xfer_req = 1'b0;
        expect_cycle(0, 0, "R9 idle");

        // R5/R6/R11: repeated collisions
        xfer_req = 1'b1;
        expect_cycle(1, 0, "R6 first claim");
        while (sb.size() > 0) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            collide_and_measure(gaps[k]);
            check(gaps[k] >= 2 && gaps[k] <= 17, "R6 backoff gap", gaps[k], 2);
        end
        distinct = 0;
        for (int k = 1; k < 6; k++) if (gaps[k] != gaps[0]) distinct = 1;
        check(distinct == 1, "R11 delays vary", distinct, 1);

        // now in claim window with no rival: win (R3), then R1 reset while owning
        expect_cycle(1, 1, "R3 win after retry");
        rst = 1'b1;
        expect_cycle(0, 0, "R1 reset while owning");
        rst = 1'b0; xfer_req = 1'b0;
        expect_cycle(0, 0, "R1 idle after reset");
        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule